// File: doc/BRIEF.md
# Home-Node Coherence Directory Controller

This block is the directory controller of one home node in a directory-based cache-coherence system. For every memory line it owns, it keeps a coherence state and a sharer vector with one bit per processor. It also holds a small line-data store. Caches send it three kinds of message: shared-read requests, exclusive-ownership requests, and invalidation acknowledgements. Owners also send it write-back data.

The controller answers with grants (shared or exclusive), with negative acknowledgements, or with invalidation requests. An invalidation request can target the sharers of a line or recall the single modified owner. A line moves through four states:
- readable by a set of sharers;
- written by one owner;
- transient while invalidation acknowledgements are still arriving;
- transient while the owner's data is returning.

Only one transaction per line may be open. A new request to a line in a transient state is refused with a negative acknowledgement, and the requester retries later. The block accepts one message per cycle and answers one cycle later with at most one outgoing message.

Top module: `home_dir_ctrl`

## Requirements
- R1: After reset every line is readable with an empty sharer set, every line's data is zero, and `rsp_valid` and `inv_valid` are low.
- R2: A shared request (`req_kind`=0) to a readable line produces, one cycle later, `rsp_kind`=0 to the requester carrying the line data, and adds the requester to the sharer set.
- R3: An exclusive request (`req_kind`=1) to a readable line whose sharer set holds no processor other than the requester produces, one cycle later, `rsp_kind`=1 to the requester, and the line becomes owned by the requester.
- R4: An exclusive request to a readable line that has other sharers produces, one cycle later, `inv_valid` with `inv_recall`=0 and `inv_mask` equal to the sharer set minus the requester's bit (bit i = processor i), and the line becomes invalidation-pending.
- R5: An invalidation acknowledgement (`req_kind`=2) from a target of an invalidation-pending line clears that target's bit. The acknowledgements before the last produce no output. The last one produces, one cycle later, `rsp_kind`=1 to the waiting requester, and the line becomes owned by that requester.
- R6: A shared or exclusive request to an owned line produces, one cycle later, `inv_valid` with `inv_recall`=1 and a one-hot `inv_mask` naming the owner, and the line becomes write-back-pending.
- R7: Write-back data (`req_kind`=3) from the owner of a write-back-pending line is stored as the line data. It also produces, one cycle later, a grant to the waiting requester carrying that data: `rsp_kind`=0 if the requester asked for a shared copy (the line becomes readable by that requester alone), or `rsp_kind`=1 if it asked for exclusive ownership (the line becomes owned by it).
- R8: A shared or exclusive request to a line in either transient state produces, one cycle later, `rsp_kind`=2 (negative acknowledgement) to the requester, and the line is left unchanged.
- R9: An acknowledgement or write-back that does not match its line's pending state or its expected sender produces no output and leaves the line's state, sharers and data unchanged.
- R10: `rsp_valid` and `inv_valid` are never high together, and each is high only in the cycle after an accepted message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Incoming message present this cycle |
| req_kind | input | 2 | 0 shared request, 1 exclusive request, 2 invalidation ack, 3 write-back data |
| req_src | input | SRC_W | Sending processor |
| req_line | input | LINE_W | Line index at this home node |
| req_data | input | DATA_W | Line data carried by a write-back |
| rsp_valid | output | 1 | Grant or refusal is valid |
| rsp_kind | output | 2 | 0 shared grant, 1 exclusive grant, 2 negative acknowledgement |
| rsp_dst | output | SRC_W | Processor the response goes to |
| rsp_line | output | LINE_W | Line of the response |
| rsp_data | output | DATA_W | Line data for grants |
| inv_valid | output | 1 | Invalidation or recall is valid |
| inv_recall | output | 1 | 1: recall of the modified owner, 0: sharer invalidation |
| inv_mask | output | NPROC | Processors that receive the request |
| inv_line | output | LINE_W | Line being invalidated or recalled |

## Verification
The bench targets four kinds of corner case:
- A requester that already holds a shared copy. A design that failed to drop it from the targets would invalidate the requester, or would wait forever for an acknowledgement that never comes.
- Acknowledgements that arrive one by one. A design that granted early would answer on the first one; a design that ignored the sender would accept an acknowledgement from a processor that was never a target.
- Write-backs. The bench checks that the returned data both reaches the waiting requester and lands in the line store; a design that forwarded stale data would show zero in the grant.
- Requests and acknowledgements that arrive during a transient state. A design that let them through would corrupt the pending requester or the sharer vector, and a later invalidation mask would show it.

// File: rtl/home_dir_pkg.sv
// Shared encodings for the home-node directory controller.
package home_dir_pkg;
    typedef enum logic [1:0] {
        LS_READ    = 2'd0,   // shared by sharer set, memory valid
        LS_OWNED   = 2'd1,   // modified at single owner
        LS_INV_PND = 2'd2,   // awaiting invalidation acks
        LS_WB_PND  = 2'd3    // awaiting owner write-back
    } line_st_e;

    typedef enum logic [1:0] {
        MSG_SH_REQ  = 2'd0,
        MSG_EX_REQ  = 2'd1,
        MSG_INV_ACK = 2'd2,
        MSG_WB_DATA = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        RSP_SHARED = 2'd0,
        RSP_EXCL   = 2'd1,
        RSP_NACK   = 2'd2
    } rsp_kind_e;
endpackage

// File: rtl/home_dir_table.sv
// Per-line directory storage: state, sharer vector, pending requester,
// pending request kind and line data. One read port (combinational by
// index) and one write port for directory fields plus one data write port.
// Assumes at most one update per cycle, issued by the decision engine.
module home_dir_table
    import home_dir_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int NLINES = 8,
    parameter int DATA_W = 32,
    localparam int SRC_W  = $clog2(NPROC),
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LINE_W-1:0] idx,
    output line_st_e          rd_st,
    output logic [NPROC-1:0]  rd_shr,
    output logic [SRC_W-1:0]  rd_pid,
    output logic              rd_pex,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  line_st_e          wr_st,
    input  logic [NPROC-1:0]  wr_shr,
    input  logic [SRC_W-1:0]  wr_pid,
    input  logic              wr_pex,
    input  logic              dwr_en,
    input  logic [DATA_W-1:0] dwr_data
);
    line_st_e          st_a  [NLINES];
    logic [NPROC-1:0]  shr_a [NLINES];
    logic [SRC_W-1:0]  pid_a [NLINES];
    logic              pex_a [NLINES];
    logic [DATA_W-1:0] dat_a [NLINES];

    for (genvar i = 0; i < NLINES; i++) begin : g_line
        localparam logic [LINE_W-1:0] MY_IDX = LINE_W'(i);
        line_st_e          st_r;
        logic [NPROC-1:0]  shr_r;
        logic [SRC_W-1:0]  pid_r;
        logic              pex_r;
        logic [DATA_W-1:0] dat_r;

        // Directory fields of this line: reset to uncached, else take update.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r  <= LS_READ;
                shr_r <= '0;
                pid_r <= '0;
                pex_r <= 1'b0;
            end else if (wr_en && idx == MY_IDX) begin
                st_r  <= wr_st;
                shr_r <= wr_shr;
                pid_r <= wr_pid;
                pex_r <= wr_pex;
            end
        end

        // Line data of this line: cleared on reset, written by write-backs.
        always_ff @(posedge clk) begin
            if (!rst_n)                        dat_r <= '0;
            else if (dwr_en && idx == MY_IDX) dat_r <= dwr_data;
        end

        assign st_a[i]  = st_r;
        assign shr_a[i] = shr_r;
        assign pid_a[i] = pid_r;
        assign pex_a[i] = pex_r;
        assign dat_a[i] = dat_r;

        // R6: an owned or write-back-pending line names exactly one holder
        owner_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_r == LS_OWNED || st_r == LS_WB_PND) |-> $onehot(shr_r));
        // R5: an invalidation-pending line always has targets outstanding
        pend_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (st_r == LS_INV_PND) |-> (shr_r != '0));
    end

    assign rd_st   = st_a[idx];
    assign rd_shr  = shr_a[idx];
    assign rd_pid  = pid_a[idx];
    assign rd_pex  = pex_a[idx];
    assign rd_data = dat_a[idx];
endmodule

// File: rtl/home_dir_engine.sv
// Combinational protocol decision for one incoming message: from the
// message and the addressed line's directory entry it computes the entry
// update, a data write, and at most one outgoing message. Assumes an owner
// never re-requests its own owned line.
module home_dir_engine
    import home_dir_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int DATA_W = 32,
    localparam int SRC_W = $clog2(NPROC)
) (
    input  logic              in_valid,
    input  logic [1:0]        in_kind,
    input  logic [SRC_W-1:0]  in_src,
    input  logic [DATA_W-1:0] in_data,
    input  line_st_e          cur_st,
    input  logic [NPROC-1:0]  cur_shr,
    input  logic [SRC_W-1:0]  cur_pid,
    input  logic              cur_pex,
    input  logic [DATA_W-1:0] cur_data,
    output logic              upd_en,
    output line_st_e          upd_st,
    output logic [NPROC-1:0]  upd_shr,
    output logic [SRC_W-1:0]  upd_pid,
    output logic              upd_pex,
    output logic              dwr_en,
    output logic              o_rsp,
    output logic [1:0]        o_rsp_kind,
    output logic [SRC_W-1:0]  o_rsp_dst,
    output logic [DATA_W-1:0] o_rsp_data,
    output logic              o_inv,
    output logic              o_inv_recall,
    output logic [NPROC-1:0]  o_inv_mask
);
    logic [NPROC-1:0] src_bit, pid_bit, others, remain;
    req_kind_e        kind;

    // One-hot bits of the sender and of the waiting requester.
    always_comb begin
        src_bit = '0;
        src_bit[in_src] = 1'b1;
        pid_bit = '0;
        pid_bit[cur_pid] = 1'b1;
    end

    assign kind   = req_kind_e'(in_kind);
    assign others = cur_shr & ~src_bit;
    assign remain = cur_shr & ~src_bit;

    // Protocol transitions for the addressed line.
    always_comb begin
        upd_en       = 1'b0;
        upd_st       = cur_st;
        upd_shr      = cur_shr;
        upd_pid      = cur_pid;
        upd_pex      = cur_pex;
        dwr_en       = 1'b0;
        o_rsp        = 1'b0;
        o_rsp_kind   = RSP_SHARED;
        o_rsp_dst    = in_src;
        o_rsp_data   = cur_data;
        o_inv        = 1'b0;
        o_inv_recall = 1'b0;
        o_inv_mask   = '0;
        if (in_valid) begin
            unique case (kind)
                MSG_SH_REQ, MSG_EX_REQ: begin
                    unique case (cur_st)
                        LS_READ: begin
                            upd_en = 1'b1;
                            if (kind == MSG_SH_REQ) begin
                                upd_shr    = cur_shr | src_bit;
                                o_rsp      = 1'b1;
                                o_rsp_kind = RSP_SHARED;
                            end else if (others == '0) begin
                                upd_st     = LS_OWNED;
                                upd_shr    = src_bit;
                                o_rsp      = 1'b1;
                                o_rsp_kind = RSP_EXCL;
                            end else begin
                                upd_st     = LS_INV_PND;
                                upd_shr    = others;
                                upd_pid    = in_src;
                                upd_pex    = 1'b1;
                                o_inv      = 1'b1;
                                o_inv_mask = others;
                            end
                        end
                        LS_OWNED: begin
                            upd_en       = 1'b1;
                            upd_st       = LS_WB_PND;
                            upd_pid      = in_src;
                            upd_pex      = (kind == MSG_EX_REQ);
                            o_inv        = 1'b1;
                            o_inv_recall = 1'b1;
                            o_inv_mask   = cur_shr;
                        end
                        default: begin
                            o_rsp      = 1'b1;
                            o_rsp_kind = RSP_NACK;
                        end
                    endcase
                end
                MSG_INV_ACK: begin
                    if (cur_st == LS_INV_PND && (cur_shr & src_bit) != '0) begin
                        upd_en = 1'b1;
                        if (remain == '0) begin
                            upd_st     = LS_OWNED;
                            upd_shr    = pid_bit;
                            o_rsp      = 1'b1;
                            o_rsp_kind = RSP_EXCL;
                            o_rsp_dst  = cur_pid;
                        end else begin
                            upd_shr = remain;
                        end
                    end
                end
                MSG_WB_DATA: begin
                    if (cur_st == LS_WB_PND && (cur_shr & src_bit) != '0) begin
                        upd_en     = 1'b1;
                        dwr_en     = 1'b1;
                        upd_st     = cur_pex ? LS_OWNED : LS_READ;
                        upd_shr    = pid_bit;
                        o_rsp      = 1'b1;
                        o_rsp_kind = cur_pex ? RSP_EXCL : RSP_SHARED;
                        o_rsp_dst  = cur_pid;
                        o_rsp_data = in_data;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/home_dir_ctrl.sv
// Home-node directory controller top. Accepts one coherence message per
// cycle (no back-pressure), decides with home_dir_engine against the entry
// held in home_dir_table, and registers a single outgoing message that is
// visible the following cycle. Assumes reliable, in-order delivery and one
// open transaction per line; conflicting requests are refused.
module home_dir_ctrl
    import home_dir_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int NLINES = 8,
    parameter int DATA_W = 32,
    localparam int SRC_W  = $clog2(NPROC),
    localparam int LINE_W = $clog2(NLINES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [SRC_W-1:0]  req_src,
    input  logic [LINE_W-1:0] req_line,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [1:0]        rsp_kind,
    output logic [SRC_W-1:0]  rsp_dst,
    output logic [LINE_W-1:0] rsp_line,
    output logic [DATA_W-1:0] rsp_data,
    output logic              inv_valid,
    output logic              inv_recall,
    output logic [NPROC-1:0]  inv_mask,
    output logic [LINE_W-1:0] inv_line
);
    line_st_e          cur_st, upd_st;
    logic [NPROC-1:0]  cur_shr, upd_shr, e_mask;
    logic [SRC_W-1:0]  cur_pid, upd_pid, e_dst;
    logic              cur_pex, upd_pex, upd_en, dwr_en;
    logic [DATA_W-1:0] cur_data, e_data;
    logic              e_rsp, e_inv, e_recall;
    logic [1:0]        e_kind;

    home_dir_table #(.NPROC(NPROC), .NLINES(NLINES), .DATA_W(DATA_W)) u_table (
        .clk(clk), .rst_n(rst_n), .idx(req_line),
        .rd_st(cur_st), .rd_shr(cur_shr), .rd_pid(cur_pid), .rd_pex(cur_pex),
        .rd_data(cur_data),
        .wr_en(upd_en), .wr_st(upd_st), .wr_shr(upd_shr), .wr_pid(upd_pid),
        .wr_pex(upd_pex), .dwr_en(dwr_en), .dwr_data(req_data)
    );

    home_dir_engine #(.NPROC(NPROC), .DATA_W(DATA_W)) u_engine (
        .in_valid(req_valid), .in_kind(req_kind), .in_src(req_src),
        .in_data(req_data),
        .cur_st(cur_st), .cur_shr(cur_shr), .cur_pid(cur_pid),
        .cur_pex(cur_pex), .cur_data(cur_data),
        .upd_en(upd_en), .upd_st(upd_st), .upd_shr(upd_shr),
        .upd_pid(upd_pid), .upd_pex(upd_pex), .dwr_en(dwr_en),
        .o_rsp(e_rsp), .o_rsp_kind(e_kind), .o_rsp_dst(e_dst),
        .o_rsp_data(e_data), .o_inv(e_inv), .o_inv_recall(e_recall),
        .o_inv_mask(e_mask)
    );

    // Register the outgoing message so it appears one cycle after the input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_kind   <= '0;
            rsp_dst    <= '0;
            rsp_line   <= '0;
            rsp_data   <= '0;
            inv_valid  <= 1'b0;
            inv_recall <= 1'b0;
            inv_mask   <= '0;
            inv_line   <= '0;
        end else begin
            rsp_valid  <= e_rsp;
            rsp_kind   <= e_kind;
            rsp_dst    <= e_dst;
            rsp_line   <= req_line;
            rsp_data   <= e_data;
            inv_valid  <= e_inv;
            inv_recall <= e_recall;
            inv_mask   <= e_mask;
            inv_line   <= req_line;
        end
    end

    // R10
    one_msg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_valid && inv_valid));
    // R10
    msg_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || inv_valid) |-> $past(req_valid));
    // R4
    inv_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (inv_mask != '0));
    // R4
    inv_excl_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && !inv_recall) |-> !inv_mask[$past(req_src)]);
    // R6
    recall_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (inv_valid && inv_recall) |-> $onehot(inv_mask));
    // R8
    nack_to_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_kind == RSP_NACK) |->
            ($past(req_kind) inside {MSG_SH_REQ, MSG_EX_REQ}) && rsp_dst == $past(req_src));
endmodule

// File: tb/home_dir_ctrl_bench.sv
`timescale 1ns/1ps
module home_dir_ctrl_bench;
    localparam int NPROC = 4, NLINES = 8, DATA_W = 32;
    localparam int SRC_W = 2, LINE_W = 3;

    logic              clk = 1'b0, rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [1:0]        req_kind = '0;
    logic [SRC_W-1:0]  req_src = '0;
    logic [LINE_W-1:0] req_line = '0;
    logic [DATA_W-1:0] req_data = '0;
    logic              rsp_valid, inv_valid, inv_recall;
    logic [1:0]        rsp_kind;
    logic [SRC_W-1:0]  rsp_dst;
    logic [LINE_W-1:0] rsp_line, inv_line;
    logic [DATA_W-1:0] rsp_data;
    logic [NPROC-1:0]  inv_mask;

    int total = 0, bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    home_dir_ctrl #(.NPROC(NPROC), .NLINES(NLINES), .DATA_W(DATA_W)) u_home_dir_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_src(req_src), .req_line(req_line), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_kind(rsp_kind), .rsp_dst(rsp_dst),
        .rsp_line(rsp_line), .rsp_data(rsp_data), .inv_valid(inv_valid),
        .inv_recall(inv_recall), .inv_mask(inv_mask), .inv_line(inv_line)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present one message; sample the registered answer one edge later,
    // then confirm the following idle cycle is silent (R10).
    task automatic send(input logic [1:0] k, input int src, input int line, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_kind = k; req_src = SRC_W'(src);
        req_line = LINE_W'(line); req_data = d;
        @(posedge clk); #1;
    endtask

    task automatic idle_check();
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk); #1;
        chk("R10 idle silent", {62'd0, rsp_valid, inv_valid}, 64'd0);
    endtask

    task automatic exp_rsp(input string tag, input int kind, input int dst, input int line, input logic [31:0] d);
        chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd1);
        chk({tag, " inv_valid"}, 64'(inv_valid), 64'd0);
        chk({tag, " rsp_kind"}, 64'(rsp_kind), 64'(kind));
        chk({tag, " rsp_dst"}, 64'(rsp_dst), 64'(dst));
        chk({tag, " rsp_line"}, 64'(rsp_line), 64'(line));
        if (kind != 2) chk({tag, " rsp_data"}, 64'(rsp_data), 64'(d));
        idle_check();
    endtask

    task automatic exp_inv(input string tag, input int mask, input int recall, input int line);
        chk({tag, " inv_valid"}, 64'(inv_valid), 64'd1);
        chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'd0);
        chk({tag, " inv_mask"}, 64'(inv_mask), 64'(mask));
        chk({tag, " inv_recall"}, 64'(inv_recall), 64'(recall));
        chk({tag, " inv_line"}, 64'(inv_line), 64'(line));
        idle_check();
    endtask

    task automatic exp_none(input string tag);
        chk({tag, " silent"}, {62'd0, rsp_valid, inv_valid}, 64'd0);
        idle_check();
    endtask

    // Kinds: 0 shared req, 1 excl req, 2 inv ack, 3 write-back.
    task automatic t_reset();
        chk("R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
        chk("R1 reset inv_valid", 64'(inv_valid), 64'd0);
        send(0, 0, 0, 0); exp_rsp("R1 R2 first read zero", 0, 0, 0, 0);
    endtask

    task automatic t_shared();
        send(0, 1, 1, 0); exp_rsp("R2 read p1", 0, 1, 1, 0);
        send(0, 2, 1, 0); exp_rsp("R2 read p2", 0, 2, 1, 0);
    endtask

    task automatic t_excl_direct();
        send(1, 3, 2, 0); exp_rsp("R3 excl uncached", 1, 3, 2, 0);
        send(0, 0, 3, 0); exp_rsp("R2 read line3", 0, 0, 3, 0);
        send(1, 0, 3, 0); exp_rsp("R3 excl only-self sharer", 1, 0, 3, 0);
    endtask

    task automatic t_invalidate();
        send(1, 2, 1, 0); exp_inv("R4 excl excludes self", 4'b0010, 0, 1);
        send(0, 0, 1, 0); exp_rsp("R8 nack during inv pend", 2, 0, 1, 0);
        send(2, 3, 1, 0); exp_none("R9 ack from non-target");
        send(2, 1, 1, 0); exp_rsp("R5 last ack grants", 1, 2, 1, 0);
        send(0, 0, 4, 0); exp_rsp("R2 line4 p0", 0, 0, 4, 0);
        send(0, 1, 4, 0); exp_rsp("R2 line4 p1", 0, 1, 4, 0);
        send(0, 3, 4, 0); exp_rsp("R2 line4 p3", 0, 3, 4, 0);
        send(1, 2, 4, 0); exp_inv("R4 three targets", 4'b1011, 0, 4);
        send(2, 0, 4, 0); exp_none("R5 ack 1 of 3 silent");
        send(2, 3, 4, 0); exp_none("R5 ack 2 of 3 silent");
        send(2, 0, 4, 0); exp_none("R9 duplicate ack ignored");
        send(2, 1, 4, 0); exp_rsp("R5 ack 3 of 3 grants", 1, 2, 4, 0);
    endtask

    task automatic t_recall();
        send(0, 0, 2, 0); exp_inv("R6 recall owner p3", 4'b1000, 1, 2);
        send(1, 1, 2, 0); exp_rsp("R8 nack during wb pend", 2, 1, 2, 0);
        send(3, 2, 2, 32'hDEAD_0000); exp_none("R9 wb from non-owner");
        send(3, 3, 2, 32'hA5A5_0001); exp_rsp("R7 wb to shared req", 0, 0, 2, 32'hA5A5_0001);
        send(0, 1, 2, 0); exp_rsp("R7 memory updated", 0, 1, 2, 32'hA5A5_0001);
        send(1, 0, 4, 0); exp_inv("R6 recall owner p2", 4'b0100, 1, 4);
        send(3, 2, 4, 32'h0000_1234); exp_rsp("R7 wb to excl req", 1, 0, 4, 32'h0000_1234);
        send(0, 1, 4, 0); exp_inv("R7 new owner p0", 4'b0001, 1, 4);
        send(3, 0, 4, 32'h0000_5678); exp_rsp("R7 shared after recall", 0, 1, 4, 32'h0000_5678);
    endtask

    task automatic t_stray();
        send(2, 0, 0, 0); exp_none("R9 ack to readable line");
        send(3, 0, 0, 32'hFFFF_FFFF); exp_none("R9 wb to readable line");
        send(1, 1, 0, 0); exp_inv("R9 sharers unchanged", 4'b0001, 0, 0);
        send(2, 0, 0, 0); exp_rsp("R5 single ack grants", 1, 1, 0, 0);
        send(1, 2, 0, 0); exp_inv("R9 data unchanged recall", 4'b0010, 1, 0);
        send(3, 1, 0, 32'h0000_0077); exp_rsp("R9 R7 wb after stray", 1, 2, 0, 32'h0000_0077);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        t_reset();
        t_shared();
        t_excl_direct();
        t_invalidate();
        t_recall();
        t_stray();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule